// File: doc/BRIEF.md
# In-Order Completion Buffer

This block keeps a record of every instruction in flight between dispatch and completion, so that the architectural state stays precise when an exception occurs. Dispatch claims a group of consecutive slots in program order. Each slot holds the index of the rename-buffer entry that will receive the instruction's result. Execution units report a slot as done once that result has been written to the rename buffer, and they can tag the report with an exception.

On every cycle the block looks at the oldest slots. It retires the longest unbroken run of finished, exception-free slots, up to four per cycle, oldest first. For each retiring slot it drives the rename index, which tells the register-file side to copy that rename entry into the architectural register. If the oldest slot has finished with an exception, nothing retires in that cycle. The block then reports the slot index and flushes the whole buffer.

Allocation uses a valid/ready handshake. A request for a group is accepted only in a cycle where both `alloc_valid` and `alloc_ready` are high. While `alloc_ready` is low, dispatch must keep its request and wait. The commit lanes and the exception/flush pins have no back-pressure: the consumer must take them in the cycle they appear.

Top module: `cb_completion_buf`

## Requirements
- R1: After reset the buffer is empty, `alloc_tag` is 0, `alloc_ready` is high for any request of 0 to 4 slots, and no retire lane, `exc_valid` or `flush` is active.
- R2: An accepted request of n slots takes the consecutive slot indices `alloc_tag`, `alloc_tag`+1, …, `alloc_tag`+n-1, modulo 16. Lane k of `alloc_rn` (bits k*6+5..k*6) belongs to slot `alloc_tag`+k. After the request, `alloc_tag` advances by n.
- R3: `alloc_ready` is high exactly when no flush is active, `alloc_count` ≤ 4, and the free slots (16 minus occupied, counted before this cycle's retirements) are at least `alloc_count`. A request is never accepted while `alloc_ready` is low.
- R4: Retire lanes carry slots oldest-first from lane 0. `ret_valid` is contiguous from bit 0. Lane k of `ret_rn` (bits k*6+5..k*6) carries the rename index stored for that slot.
- R5: At most four slots retire per cycle. If more are finished, the rest retire in later cycles, still in order.
- R6: Retirement stops at the first slot that is not finished, even if younger slots are finished.
- R7: When the oldest slot is finished with its exception flag set, `exc_valid` and `flush` are high and `exc_tag` gives that slot's index. No lane retires. At the next clock edge every slot is freed, and `alloc_tag` then equals the reported index.
- R8: An excepting slot that is not the oldest stops retirement at its position. The finished slots older than it retire normally before it is reported.
- R9: Slot indices wrap from 15 to 0. A buffer holding 16 slots refuses any nonzero request, and it is still told apart from an empty buffer.
- R10: A finish report naming a slot that is not occupied has no effect. That slot, once allocated later, does not retire until it is itself reported finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Dispatch requests slots |
| alloc_count | input | 3 | Number of slots requested (0 to 4) |
| alloc_rn | input | 24 | Four 6-bit rename indices, lane 0 in the low bits |
| alloc_ready | output | 1 | Request can be accepted this cycle |
| alloc_tag | output | 4 | Index of the first slot the request will take |
| fin_valid | input | 3 | One finish report per execution port |
| fin_tag | input | 12 | Three 4-bit slot indices, port 0 in the low bits |
| fin_exc | input | 3 | Exception flag for each finish report |
| ret_valid | output | 4 | Retire lanes active this cycle |
| ret_rn | output | 24 | Rename index of each retiring slot |
| exc_valid | output | 1 | Oldest slot finished with an exception |
| exc_tag | output | 4 | Index of the excepting slot (0 when none) |
| flush | output | 1 | Free every slot at the next edge |

## Verification
`alloc_ready` and `alloc_tag` respond to the request in the same cycle, because they are computed from the stored pointers and `alloc_count`. A finish report applied at one rising edge appears on the retire lanes, or on `exc_valid`/`flush`, in the cycle that follows that edge. The retirement or flush it causes takes effect at the next edge. The bench drives inputs on the falling edge and samples every output 1 ns later. It compares those samples against a slot-level model that steps only at the rising edge. A sweep of request sizes, fill-to-full and wrap sequences, and out-of-order and excepting finish patterns is followed by a long pseudo-random mix, and all of them are checked cycle by cycle.

// File: rtl/cb_pkg.sv
package cb_pkg;
  typedef struct packed {
    logic valid;
    logic done;
    logic exc;
  } cb_slot_t;
endpackage

// File: rtl/cb_occupancy.sv
module cb_occupancy #(
  parameter int DEPTH   = 16,
  parameter int ALLOC_W = 4
) (
  input  logic [$clog2(DEPTH):0]     head,
  input  logic [$clog2(DEPTH):0]     tail,
  input  logic [$clog2(ALLOC_W+1)-1:0] alloc_count,
  input  logic                       flush,
  output logic [$clog2(DEPTH):0]     occ,
  output logic                       ready
);
  localparam int PW = $clog2(DEPTH) + 1;

  logic [PW-1:0] free_slots;

  always_comb begin
    occ        = tail - head;
    free_slots = PW'(DEPTH) - occ;
    ready      = !flush
              && (int'(alloc_count) <= ALLOC_W)
              && (PW'(alloc_count) <= free_slots);
  end
endmodule

// File: rtl/cb_retire_scan.sv
module cb_retire_scan import cb_pkg::*; #(
  parameter int DEPTH = 16,
  parameter int RET_W = 4,
  parameter int RN_W  = 6
) (
  input  logic [$clog2(DEPTH)-1:0]   head_idx,
  input  cb_slot_t                   st [DEPTH],
  input  logic [RN_W-1:0]            rn [DEPTH],
  output logic [RET_W-1:0]           ret_valid,
  output logic [RET_W*RN_W-1:0]      ret_rn,
  output logic [$clog2(RET_W+1)-1:0] ret_num,
  output logic                       exc_now
);
  localparam int IW = $clog2(DEPTH);
  localparam int NW = $clog2(RET_W + 1);

  always_comb begin
    logic          run;
    logic [IW-1:0] idx;
    exc_now   = st[head_idx].valid && st[head_idx].done && st[head_idx].exc;
    run       = !exc_now;
    ret_valid = '0;
    ret_rn    = '0;
    ret_num   = '0;
    for (int i = 0; i < RET_W; i++) begin
      idx = head_idx + IW'(i);
      if (run && st[idx].valid && st[idx].done && !st[idx].exc) begin
        ret_valid[i]            = 1'b1;
        ret_rn[i*RN_W +: RN_W]  = rn[idx];
        ret_num                 = ret_num + NW'(1);
      end else begin
        run = 1'b0;
      end
    end
  end
endmodule

// File: rtl/cb_entry_array.sv
module cb_entry_array import cb_pkg::*; #(
  parameter int DEPTH   = 16,
  parameter int ALLOC_W = 4,
  parameter int NFIN    = 3,
  parameter int RN_W    = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          flush,
  input  logic                          alloc_fire,
  input  logic [$clog2(ALLOC_W+1)-1:0]  alloc_count,
  input  logic [$clog2(DEPTH)-1:0]      tail_idx,
  input  logic [ALLOC_W*RN_W-1:0]       alloc_rn,
  input  logic [NFIN-1:0]               fin_valid,
  input  logic [NFIN*$clog2(DEPTH)-1:0] fin_tag,
  input  logic [NFIN-1:0]               fin_exc,
  input  logic [DEPTH-1:0]              ret_clear,
  output cb_slot_t                      st [DEPTH],
  output logic [RN_W-1:0]               rn [DEPTH]
);
  localparam int IW = $clog2(DEPTH);

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    cb_slot_t        st_q;
    logic [RN_W-1:0] rn_q;
    logic            hit_a;
    logic [RN_W-1:0] a_rn;
    logic            hit_f;
    logic            f_exc;

    always_comb begin
      hit_a = 1'b0;
      a_rn  = '0;
      for (int a = 0; a < ALLOC_W; a++) begin
        if (alloc_fire && (a < int'(alloc_count)) && ((tail_idx + IW'(a)) == IW'(e))) begin
          hit_a = 1'b1;
          a_rn  = alloc_rn[a*RN_W +: RN_W];
        end
      end
      hit_f = 1'b0;
      f_exc = 1'b0;
      for (int p = 0; p < NFIN; p++) begin
        if (fin_valid[p] && (fin_tag[p*IW +: IW] == IW'(e))) begin
          hit_f = 1'b1;
          f_exc = f_exc | fin_exc[p];
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q <= '0;
        rn_q <= '0;
      end else if (flush) begin
        st_q <= '0;
      end else if (hit_a) begin
        st_q <= '{valid: 1'b1, done: 1'b0, exc: 1'b0};
        rn_q <= a_rn;
      end else if (ret_clear[e]) begin
        st_q.valid <= 1'b0;
      end else if (hit_f && st_q.valid) begin
        st_q.done <= 1'b1;
        st_q.exc  <= st_q.exc | f_exc;
      end
    end

    assign st[e] = st_q;
    assign rn[e] = rn_q;
  end
endmodule

// File: rtl/cb_completion_buf.sv
module cb_completion_buf import cb_pkg::*; #(
  parameter int DEPTH   = 16,
  parameter int ALLOC_W = 4,
  parameter int RET_W   = 4,
  parameter int NFIN    = 3,
  parameter int RN_W    = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          alloc_valid,
  input  logic [$clog2(ALLOC_W+1)-1:0]  alloc_count,
  input  logic [ALLOC_W*RN_W-1:0]       alloc_rn,
  output logic                          alloc_ready,
  output logic [$clog2(DEPTH)-1:0]      alloc_tag,
  input  logic [NFIN-1:0]               fin_valid,
  input  logic [NFIN*$clog2(DEPTH)-1:0] fin_tag,
  input  logic [NFIN-1:0]               fin_exc,
  output logic [RET_W-1:0]              ret_valid,
  output logic [RET_W*RN_W-1:0]         ret_rn,
  output logic                          exc_valid,
  output logic [$clog2(DEPTH)-1:0]      exc_tag,
  output logic                          flush
);
  localparam int IW = $clog2(DEPTH);
  localparam int PW = IW + 1;
  localparam int NW = $clog2(RET_W + 1);

  logic [PW-1:0]    head_q, tail_q, occ_w;
  logic [NW-1:0]    ret_num;
  logic             exc_now;
  logic             alloc_fire;
  logic [DEPTH-1:0] ret_clear;
  cb_slot_t         st [DEPTH];
  logic [RN_W-1:0]  rn [DEPTH];

  cb_occupancy #(.DEPTH(DEPTH), .ALLOC_W(ALLOC_W)) u_occ (
    .head(head_q), .tail(tail_q), .alloc_count(alloc_count),
    .flush(exc_now), .occ(occ_w), .ready(alloc_ready)
  );

  cb_retire_scan #(.DEPTH(DEPTH), .RET_W(RET_W), .RN_W(RN_W)) u_scan (
    .head_idx(head_q[IW-1:0]), .st(st), .rn(rn),
    .ret_valid(ret_valid), .ret_rn(ret_rn), .ret_num(ret_num), .exc_now(exc_now)
  );

  cb_entry_array #(.DEPTH(DEPTH), .ALLOC_W(ALLOC_W), .NFIN(NFIN), .RN_W(RN_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .flush(exc_now), .alloc_fire(alloc_fire),
    .alloc_count(alloc_count), .tail_idx(tail_q[IW-1:0]), .alloc_rn(alloc_rn),
    .fin_valid(fin_valid), .fin_tag(fin_tag), .fin_exc(fin_exc),
    .ret_clear(ret_clear), .st(st), .rn(rn)
  );

  assign alloc_fire = alloc_valid && alloc_ready;
  assign alloc_tag  = tail_q[IW-1:0];
  assign exc_valid  = exc_now;
  assign flush      = exc_now;
  assign exc_tag    = exc_now ? head_q[IW-1:0] : '0;

  always_comb begin
    ret_clear = '0;
    for (int i = 0; i < RET_W; i++) begin
      if (ret_valid[i]) ret_clear[head_q[IW-1:0] + IW'(i)] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else if (exc_now) begin
      tail_q <= head_q;
    end else begin
      head_q <= head_q + PW'(ret_num);
      if (alloc_fire) tail_q <= tail_q + PW'(alloc_count);
    end
  end
endmodule

// File: rtl/cb_checker.sv
module cb_checker #(
  parameter int DEPTH   = 16,
  parameter int ALLOC_W = 4,
  parameter int RET_W   = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         alloc_valid,
  input logic                         alloc_ready,
  input logic [$clog2(ALLOC_W+1)-1:0] alloc_count,
  input logic [$clog2(DEPTH)-1:0]     alloc_tag,
  input logic [RET_W-1:0]             ret_valid,
  input logic                         exc_valid,
  input logic [$clog2(DEPTH)-1:0]     exc_tag,
  input logic                         flush,
  input logic [$clog2(DEPTH):0]       occ
);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ) <= DEPTH);

  p_occ_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready) |=>
      int'(occ) == int'($past(occ)) + int'($past(alloc_count)) - $countones($past(ret_valid)));

  p_full_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(occ) == DEPTH && alloc_count != 0) |-> !alloc_ready);

  for (genvar i = 0; i + 1 < RET_W; i++) begin : g_lane
    p_contig_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ret_valid[i+1] |-> ret_valid[i]);
  end

  p_flush_no_retire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (ret_valid == '0));

  p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (occ == '0));

  p_flush_tag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> (alloc_tag == $past(exc_tag)));
endmodule

bind cb_completion_buf cb_checker #(.DEPTH(DEPTH), .ALLOC_W(ALLOC_W), .RET_W(RET_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
  .alloc_count(alloc_count), .alloc_tag(alloc_tag), .ret_valid(ret_valid),
  .exc_valid(exc_valid), .exc_tag(exc_tag), .flush(flush), .occ(occ_w)
);

// File: tb/tb_cb_completion_buf.sv
module tb_cb_completion_buf;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid;
  logic [2:0]  alloc_count;
  logic [23:0] alloc_rn;
  logic        alloc_ready;
  logic [3:0]  alloc_tag;
  logic [2:0]  fin_valid;
  logic [11:0] fin_tag;
  logic [2:0]  fin_exc;
  logic [3:0]  ret_valid;
  logic [23:0] ret_rn;
  logic        exc_valid;
  logic [3:0]  exc_tag;
  logic        flush;

  int checks = 0;
  int fails  = 0;

  bit mv [16];
  bit md [16];
  bit me [16];
  int mrn [16];
  int mh = 0;
  int mt = 0;
  logic [31:0] rs = 32'h1234_abcd;

  always #4 clk = ~clk;

  cb_completion_buf dut (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_count(alloc_count),
    .alloc_rn(alloc_rn), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
    .fin_valid(fin_valid), .fin_tag(fin_tag), .fin_exc(fin_exc),
    .ret_valid(ret_valid), .ret_rn(ret_rn), .exc_valid(exc_valid),
    .exc_tag(exc_tag), .flush(flush)
  );

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog (R1..R10 run incomplete) got=hang exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  function automatic logic [31:0] rnd();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
    return rs;
  endfunction

  function automatic int occ_m();
    return (mt - mh) & 31;
  endfunction

  task automatic chk(input string sc, input string fld, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got=%0h exp=%0h", sc, fld, got, exp);
    end
  endtask

  task automatic idle();
    alloc_valid = 1'b0;
    alloc_count = '0;
    alloc_rn    = '0;
    fin_valid   = '0;
    fin_tag     = '0;
    fin_exc     = '0;
  endtask

  task automatic set_alloc(input int n, input int base);
    alloc_valid = 1'b1;
    alloc_count = 3'(n);
    for (int a = 0; a < 4; a++) alloc_rn[a*6 +: 6] = 6'(base + a);
  endtask

  task automatic set_fin(input int p, input int tag, input bit ex);
    fin_valid[p]       = 1'b1;
    fin_tag[p*4 +: 4]  = 4'(tag);
    fin_exc[p]         = ex;
  endtask

  task automatic tick(input string sc);
    int  occ, h, k;
    bit  ef, rdy, run;
    int  e;
    #1;
    occ = occ_m();
    h   = mh % 16;
    ef  = mv[h] && md[h] && me[h];
    k   = 0;
    run = !ef;
    for (int j = 0; j < 4; j++) begin
      e = (mh + j) % 16;
      if (run && mv[e] && md[e] && !me[e]) k++;
      else run = 1'b0;
    end
    rdy = !ef && (alloc_count <= 4) && (occ + int'(alloc_count) <= 16);
    chk(sc, "R3 alloc_ready", 32'(alloc_ready), 32'(rdy));
    chk(sc, "R2 alloc_tag", 32'(alloc_tag), 32'(mt % 16));
    chk(sc, "R4/R6 ret_valid", 32'(ret_valid), 32'((1 << k) - 1));
    chk(sc, "R5 retire count", 32'($countones(ret_valid)), 32'(k));
    for (int j = 0; j < k; j++)
      chk(sc, "R4 ret_rn", 32'(ret_rn[j*6 +: 6]), 32'(mrn[(mh + j) % 16]));
    chk(sc, "R7 exc_valid", 32'(exc_valid), 32'(ef));
    chk(sc, "R7 flush", 32'(flush), 32'(ef));
    if (ef) chk(sc, "R7 exc_tag", 32'(exc_tag), 32'(h));
    @(posedge clk);
    if (ef) begin
      for (int j = 0; j < 16; j++) mv[j] = 1'b0;
      mt = mh;
    end else begin
      for (int j = 0; j < k; j++) mv[(mh + j) % 16] = 1'b0;
      mh = (mh + k) & 31;
      for (int p = 0; p < 3; p++) begin
        e = int'(fin_tag[p*4 +: 4]);
        if (fin_valid[p] && mv[e]) begin
          md[e] = 1'b1;
          me[e] = me[e] | fin_exc[p];
        end
      end
      if (alloc_valid && rdy) begin
        for (int a = 0; a < int'(alloc_count); a++) begin
          e = (mt + a) % 16;
          mv[e]  = 1'b1;
          md[e]  = 1'b0;
          me[e]  = 1'b0;
          mrn[e] = int'(alloc_rn[a*6 +: 6]);
        end
        mt = (mt + int'(alloc_count)) & 31;
      end
    end
    @(negedge clk);
  endtask

  task automatic drain(input string sc);
    int n, e;
    for (int it = 0; it < 64; it++) begin
      if (occ_m() == 0) break;
      idle();
      n = 0;
      for (int j = 0; j < occ_m(); j++) begin
        e = (mh + j) % 16;
        if (n < 3 && mv[e] && !md[e]) begin
          set_fin(n, e, 1'b0);
          n++;
        end
      end
      tick(sc);
    end
    idle();
  endtask

  initial begin
    logic [31:0] r, r2;
    int off, tg, occ;
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    alloc_count = 3'd4;
    #1;
    chk("R1 reset", "alloc_ready", 32'(alloc_ready), 32'd1);
    chk("R1 reset", "alloc_tag", 32'(alloc_tag), 32'd0);
    chk("R1 reset", "ret_valid", 32'(ret_valid), 32'd0);
    chk("R1 reset", "exc_valid", 32'(exc_valid), 32'd0);
    chk("R1 reset", "flush", 32'(flush), 32'd0);
    idle();
    @(negedge clk);

    // R3: request-size sweep on an empty buffer
    for (int n = 0; n <= 7; n++) begin
      set_alloc(n, 8 * n);
      tick("R3 size sweep");
      drain("R3 size sweep drain");
    end

    // R9: fill to full, refuse, drain, wrap several times
    for (int rep = 0; rep < 3; rep++) begin
      for (int g = 0; g < 5; g++) begin
        idle();
        set_alloc(4, 16 * g + rep);
        tick("R9 fill");
      end
      for (int n = 1; n <= 4; n++) begin
        idle();
        set_alloc(n, 0);
        tick("R9 full refuse");
      end
      drain("R9 drain wrap");
      idle();
      set_alloc(3, 40);
      tick("R9 offset");
      drain("R9 offset drain");
    end

    // R6/R5: younger slots finish first; oldest last releases a burst
    for (int grp = 1; grp <= 4; grp++) begin
      idle();
      set_alloc(4, 20);
      tick("R6 alloc");
      idle();
      set_alloc(grp, 30);
      tick("R6 alloc");
      idle();
      for (int j = 1; j < 4; j++) set_fin(j - 1, (mh + j) % 16, 1'b0);
      tick("R6 younger finished");
      idle();
      tick("R6 head pending");
      idle();
      for (int j = 4; j < 4 + grp && j < 7; j++) set_fin(j - 4, (mh + j) % 16, 1'b0);
      tick("R5 second group");
      idle();
      set_fin(0, mh % 16, 1'b0);
      tick("R5 head finishes");
      idle();
      tick("R5 burst of four");
      tick("R5 remainder");
      drain("R6 drain");
    end

    // R7/R8: exception at each position of a group
    for (int pos = 0; pos < 4; pos++) begin
      idle();
      set_alloc(4, 50);
      tick("R8 alloc");
      idle();
      set_alloc(2, 60);
      tick("R8 alloc younger");
      idle();
      for (int j = 3; j >= 1; j--) set_fin(3 - j, (mh + j) % 16, j == pos);
      tick("R8 finish tail");
      idle();
      set_fin(0, mh % 16, pos == 0);
      tick("R7 finish head");
      for (int w = 0; w < 4; w++) begin
        idle();
        tick("R7/R8 settle");
      end
      drain("R7 drain");
    end

    // R10: finish report to free slots has no effect
    for (int t = 0; t < 16; t++) begin
      idle();
      set_fin(0, t, 1'b0);
      set_fin(1, (t + 5) % 16, 1'b1);
      tick("R10 stray finish");
      idle();
      set_alloc(1, t);
      tick("R10 alloc after stray");
      idle();
      tick("R10 not retired");
      drain("R10 drain");
    end

    // mixed pseudo-random traffic, all rules checked each cycle
    for (int c = 0; c < 6000; c++) begin
      idle();
      r = rnd();
      if (r[2:0] != 0) set_alloc(int'(r[5:3]) % 6, int'(r[11:6]));
      occ = occ_m();
      for (int p = 0; p < 3; p++) begin
        r2 = rnd();
        if (r2[0] && occ > 0) begin
          off = int'(r2[8:1]) % occ;
          tg  = (mh + off) % 16;
          if (r2[14:9] == 0) tg = int'(r2[19:16]);
          set_fin(p, tg, r2[25:20] == 0);
        end
      end
      tick("R10 mixed traffic");
    end
    drain("mixed drain");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule